// File: doc/BRIEF.md
# Sampling Delay Tuning Sweep Controller

This block calibrates the sampling (or launch) delay that a host uses on a high-speed card interface. After a start request it walks an 8-bit delay code upward from the lowest setting to the highest. At every setting it asks an external transaction engine for one test exchange and grades the outcome as pass or fail. When the last setting has been graded, it drives the delay line with the centre of the longest unbroken run of passing settings. It also reports the first and last codes of that run, or flags that no setting passed at all. Such a flag usually points to a wiring or signal-integrity fault.

Two test flavours are offered, and the flavour is latched at start. The read-path flavour asks the engine for a tuning command followed by a single-sector read. A setting then passes only if both the command response and the data arrive on time and free of errors. The write-path flavour asks for a status command, and a setting passes when its response comes back correctly. The delay line and the transaction engine live outside this block. The block only drives the delay code and a request, and it consumes an acknowledge carrying the two quality flags.

The longest run is tracked on the fly, so no per-setting result storage is kept. Ties between runs of equal length go to the run that started at the lower delay code.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: A one-cycle `start_i` pulse while idle raises `busy_o` in the next cycle. In that cycle `dly_o` is 0 and `test_req_o` is high. A `start_i` (or a `mode_i` change) while `busy_o` is high has no effect on the sweep in progress.
- R2: Every delay code from 0 to 255 is tested exactly once, in ascending order, so one sweep takes 256 acknowledges. `test_req_o` stays high, with `dly_o` unchanged, until `test_ack_i` is seen. The code then rises by one, and `test_req_o` is low for one cycle before the next request.
- R3: With `mode_i` = 0 at start (read path), `test_kind_o` is 0. A setting passes only when `test_rsp_ok_i` and `test_data_ok_i` are both 1 in its acknowledge cycle.
- R4: With `mode_i` = 1 at start (write path), `test_kind_o` is 1. A setting passes when `test_rsp_ok_i` is 1, and `test_data_ok_i` is ignored.
- R5: The selected window is the longest contiguous run of passing codes. When two runs are equally long, the one starting at the lower code is kept.
- R6: After a sweep with at least one pass, `win_start_o` and `win_end_o` hold the first and last codes of the window. `dly_o` holds start + ((length − 1) >> 1), with truncation; for example, a window of 10 to 70 gives 40.
- R7: After a sweep with no passing code, `no_win_o` is 1, `dly_o` is 0, and `win_start_o` = `win_end_o` = 0.
- R8: `done_o` is a one-cycle pulse, and `busy_o` falls in the same cycle. The results stay unchanged until the next sweep ends, and `no_win_o` is cleared when the next sweep starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, honoured only while idle |
| mode_i | input | 1 | Test flavour sampled at start: 0 read path, 1 write path |
| busy_o | output | 1 | High for the whole sweep |
| done_o | output | 1 | One-cycle completion pulse |
| dly_o | output | 8 | Delay code to the delay line (sweep value, then chosen value) |
| test_req_o | output | 1 | Request for one test exchange at the current code |
| test_kind_o | output | 1 | Latched test flavour for the engine |
| test_ack_i | input | 1 | Engine finished the exchange (one cycle) |
| test_rsp_ok_i | input | 1 | Command response arrived without timeout or error |
| test_data_ok_i | input | 1 | Read data arrived without timeout or CRC error |
| win_start_o | output | 8 | First code of the chosen window |
| win_end_o | output | 8 | Last code of the chosen window |
| no_win_o | output | 1 | No code passed in the last sweep |

## Verification
Two functions can land on the same step. The step at code 255 both extends the open passing run and ends the sweep, and on that same edge the run can overtake the best window so far. A run of equal length can also reach the length of the stored best one on a single step. The scoreboard provokes both of these cases. One pattern's longest run ends at 255, one pattern is a single pass at 255 only, and one pattern has two equal-length runs. In each case the delay, window bounds and error flag seen after the done pulse are compared with a brute-force search done in the bench over the same pass pattern.

// File: rtl/tune_pkg.sv
package tune_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_GAP  = 2'd2,
      ST_FIN  = 2'd3
   } sweep_st_t;

   typedef enum logic {
      MODE_READ  = 1'b0,
      MODE_WRITE = 1'b1
   } tune_mode_t;

endpackage

// File: rtl/tune_verdict.sv
module tune_verdict #(
   parameter bit READ_NEEDS_DATA = 1'b1
) (
   input  logic mode_i,
   input  logic rsp_ok_i,
   input  logic data_ok_i,
   output logic pass_o
);
   import tune_pkg::*;

   generate
      if (READ_NEEDS_DATA) begin : g_read_data
         always_comb begin
            if (tune_mode_t'(mode_i) == MODE_WRITE)
               pass_o = rsp_ok_i;
            else
               pass_o = rsp_ok_i & data_ok_i;
         end
      end else begin : g_rsp_only
         always_comb pass_o = rsp_ok_i;
      end
   endgenerate

endmodule

// File: rtl/tune_run_track.sv
module tune_run_track #(
   parameter int DLY_W = 8,
   localparam int LEN_W = DLY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             rec_i,
   input  logic             pass_i,
   input  logic [DLY_W-1:0] idx_i,
   output logic [DLY_W-1:0] best_start_o,
   output logic [LEN_W-1:0] best_len_o
);

   logic [DLY_W-1:0] cur_start;
   logic [LEN_W-1:0] cur_len;
   logic [DLY_W-1:0] run_start;
   logic [LEN_W-1:0] run_len;

   always_comb begin
      run_start = (cur_len == '0) ? idx_i : cur_start;
      run_len   = cur_len + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_start    <= '0;
         cur_len      <= '0;
         best_start_o <= '0;
         best_len_o   <= '0;
      end else if (clr_i) begin
         cur_start    <= '0;
         cur_len      <= '0;
         best_start_o <= '0;
         best_len_o   <= '0;
      end else if (rec_i) begin
         if (pass_i) begin
            cur_start <= run_start;
            cur_len   <= run_len;
            if (run_len > best_len_o) begin
               best_start_o <= run_start;
               best_len_o   <= run_len;
            end
         end else begin
            cur_len <= '0;
         end
      end
   end

   // R5: the stored best run only grows during a sweep
   a_r5_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> best_len_o >= $past(best_len_o));

   // R5: the open run can never be longer than the best one
   a_r5_open_le_best: assert property (@(posedge clk) disable iff (!rst_n)
      cur_len <= best_len_o);

   // R5: a failing step closes the open run
   a_r5_fail_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_i && !pass_i && !clr_i) |=> cur_len == '0);

endmodule

// File: rtl/tune_midpoint.sv
module tune_midpoint #(
   parameter int DLY_W = 8,
   localparam int LEN_W = DLY_W + 1
) (
   input  logic [DLY_W-1:0] start_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [DLY_W-1:0] mid_o,
   output logic [DLY_W-1:0] last_o,
   output logic             none_o
);

   logic [LEN_W-1:0] span;

   always_comb begin
      span   = len_i - 1'b1;
      none_o = (len_i == '0);
      mid_o  = start_i + span[DLY_W:1];
      last_o = start_i + span[DLY_W-1:0];
   end

endmodule

// File: rtl/tune_seq.sv
module tune_seq #(
   parameter int DLY_W   = 8,
   parameter int DLY_MIN = 0,
   parameter int DLY_MAX = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_i,
   input  logic             ack_i,
   input  logic [DLY_W-1:0] mid_i,
   input  logic [DLY_W-1:0] last_i,
   input  logic [DLY_W-1:0] best_start_i,
   input  logic             none_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             req_o,
   output logic             kind_o,
   output logic             clr_o,
   output logic             rec_o,
   output logic [DLY_W-1:0] dly_o,
   output logic [DLY_W-1:0] win_start_o,
   output logic [DLY_W-1:0] win_end_o,
   output logic             no_win_o
);
   import tune_pkg::*;

   localparam logic [DLY_W-1:0] MIN_CODE = DLY_W'(DLY_MIN);
   localparam logic [DLY_W-1:0] MAX_CODE = DLY_W'(DLY_MAX);

   sweep_st_t st;

   always_comb begin
      req_o = (st == ST_REQ);
      clr_o = (st == ST_IDLE) && start_i;
      rec_o = (st == ST_REQ) && ack_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         busy_o      <= 1'b0;
         done_o      <= 1'b0;
         kind_o      <= 1'b0;
         dly_o       <= MIN_CODE;
         win_start_o <= '0;
         win_end_o   <= '0;
         no_win_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i) begin
                  st       <= ST_REQ;
                  busy_o   <= 1'b1;
                  dly_o    <= MIN_CODE;
                  kind_o   <= mode_i;
                  no_win_o <= 1'b0;
               end
            end
            ST_REQ: begin
               if (ack_i) begin
                  if (dly_o == MAX_CODE) begin
                     st <= ST_FIN;
                  end else begin
                     dly_o <= dly_o + 1'b1;
                     st    <= ST_GAP;
                  end
               end
            end
            ST_GAP: st <= ST_REQ;
            ST_FIN: begin
               st     <= ST_IDLE;
               busy_o <= 1'b0;
               done_o <= 1'b1;
               if (none_i) begin
                  no_win_o    <= 1'b1;
                  dly_o       <= MIN_CODE;
                  win_start_o <= '0;
                  win_end_o   <= '0;
               end else begin
                  dly_o       <= mid_i;
                  win_start_o <= best_start_i;
                  win_end_o   <= last_i;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1: a sweep always begins at the lowest code
   a_r1_begin_at_min: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (dly_o == MIN_CODE && req_o));

   // R2: each graded step moves the code up by exactly one
   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && dly_o != MAX_CODE) |=> dly_o == DLY_W'($past(dly_o) + 1'b1));

   // R2: request and code hold until acknowledged
   a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i) |=> (req_o && $stable(dly_o)));

   // R2: requests only inside a sweep
   a_r2_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> busy_o);

   // R7: an empty sweep parks the code at the minimum
   a_r7_empty_parks_min: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && no_win_o) |-> (dly_o == MIN_CODE && win_start_o == '0 && win_end_o == '0));

   // R8: done is a single-cycle pulse ending busy
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $fell(busy_o));

endmodule

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl #(
   parameter int DLY_W           = 8,
   parameter int DLY_MIN         = 0,
   parameter int DLY_MAX         = 255,
   parameter bit READ_NEEDS_DATA = 1'b1,
   localparam int LEN_W = DLY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mode_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [DLY_W-1:0] dly_o,
   output logic             test_req_o,
   output logic             test_kind_o,
   input  logic             test_ack_i,
   input  logic             test_rsp_ok_i,
   input  logic             test_data_ok_i,
   output logic [DLY_W-1:0] win_start_o,
   output logic [DLY_W-1:0] win_end_o,
   output logic             no_win_o
);

   generate
      if (DLY_W < 2 || DLY_W > 16) begin : g_bad_width
         $error("tune_sweep_ctrl: DLY_W out of range");
      end
      if (DLY_MIN < 0 || DLY_MAX >= (1 << DLY_W) || DLY_MIN > DLY_MAX) begin : g_bad_range
         $error("tune_sweep_ctrl: sweep bounds do not fit the code width");
      end
   endgenerate

   logic             clr;
   logic             rec;
   logic             pass;
   logic [DLY_W-1:0] best_start;
   logic [LEN_W-1:0] best_len;
   logic [DLY_W-1:0] mid;
   logic [DLY_W-1:0] last;
   logic             none;

   tune_verdict #(.READ_NEEDS_DATA(READ_NEEDS_DATA)) u_verdict (
      .mode_i    (test_kind_o),
      .rsp_ok_i  (test_rsp_ok_i),
      .data_ok_i (test_data_ok_i),
      .pass_o    (pass)
   );

   tune_run_track #(.DLY_W(DLY_W)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr),
      .rec_i        (rec),
      .pass_i       (pass),
      .idx_i        (dly_o),
      .best_start_o (best_start),
      .best_len_o   (best_len)
   );

   tune_midpoint #(.DLY_W(DLY_W)) u_mid (
      .start_i (best_start),
      .len_i   (best_len),
      .mid_o   (mid),
      .last_o  (last),
      .none_o  (none)
   );

   tune_seq #(.DLY_W(DLY_W), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .mode_i       (mode_i),
      .ack_i        (test_ack_i),
      .mid_i        (mid),
      .last_i       (last),
      .best_start_i (best_start),
      .none_i       (none),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .req_o        (test_req_o),
      .kind_o       (test_kind_o),
      .clr_o        (clr),
      .rec_o        (rec),
      .dly_o        (dly_o),
      .win_start_o  (win_start_o),
      .win_end_o    (win_end_o),
      .no_win_o     (no_win_o)
   );

   // R6: a reported window is ordered and holds the chosen code
   a_r6_mid_inside: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !no_win_o) |-> (win_start_o <= dly_o && dly_o <= win_end_o));

endmodule

// File: tb/tb_tune_sweep_ctrl.sv
`timescale 1ns/1ps
module tb_tune_sweep_ctrl;

   localparam int NS = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       mode_i = 1'b0;
   logic       test_ack_i = 1'b0;
   logic       test_rsp_ok_i = 1'b0;
   logic       test_data_ok_i = 1'b0;
   logic       busy_o, done_o, test_req_o, test_kind_o, no_win_o;
   logic [7:0] dly_o, win_start_o, win_end_o;

   always #2 clk = ~clk;

   tune_sweep_ctrl dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .busy_o(busy_o), .done_o(done_o), .dly_o(dly_o),
      .test_req_o(test_req_o), .test_kind_o(test_kind_o),
      .test_ack_i(test_ack_i), .test_rsp_ok_i(test_rsp_ok_i),
      .test_data_ok_i(test_data_ok_i), .win_start_o(win_start_o),
      .win_end_o(win_end_o), .no_win_o(no_win_o)
   );

   typedef struct {
      int    dly;
      int    ws;
      int    we;
      bit    nw;
      string tag;
   } exp_t;

   exp_t       sb[$];
   int         checks = 0;
   int         failures = 0;
   logic [255:0] pr, pd;
   int         exp_idx = 0;
   int         acks_seen = 0;
   bit         exp_kind = 1'b0;
   int         sweeps_done = 0;
   int         lat_cnt = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // brute-force search for the longest run, earliest on ties
   function automatic exp_t model(input bit mode, input string tag);
      exp_t e;
      int best_s = 0, best_l = 0;
      for (int s = 0; s < NS; s++) begin
         int l = 0;
         while (s + l < NS && pr[s+l] && (mode || pd[s+l])) l++;
         if (l > best_l) begin best_l = l; best_s = s; end
      end
      e.tag = tag;
      if (best_l == 0) begin
         e.nw = 1; e.dly = 0; e.ws = 0; e.we = 0;
      end else begin
         e.nw = 0; e.ws = best_s; e.we = best_s + best_l - 1;
         e.dly = best_s + (best_l - 1) / 2;
      end
      return e;
   endfunction

   // transaction engine model
   initial begin
      forever begin
         @(negedge clk);
         test_ack_i = 1'b0;
         test_rsp_ok_i = ~test_rsp_ok_i;
         test_data_ok_i = ~test_data_ok_i;
         if (test_req_o) begin
            if (lat_cnt >= int'(dly_o) % 3) begin
               chk(int'(dly_o) == exp_idx, "R2", "tested code order", dly_o, exp_idx);
               chk(test_kind_o == exp_kind, exp_kind ? "R4" : "R3", "test kind",
                   test_kind_o, exp_kind);
               test_ack_i = 1'b1;
               test_rsp_ok_i = pr[dly_o];
               test_data_ok_i = pd[dly_o];
               exp_idx++;
               acks_seen++;
               lat_cnt = 0;
            end else begin
               lat_cnt++;
            end
         end
      end
   end

   // monitor: compare results against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done_o) begin
            exp_t e;
            if (sb.size() == 0) begin
               chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
               e = sb.pop_front();
               chk(no_win_o == e.nw, e.nw ? "R7" : "R5", {e.tag, " no_win"}, no_win_o, e.nw);
               chk(int'(win_start_o) == e.ws, "R5", {e.tag, " win_start"}, win_start_o, e.ws);
               chk(int'(win_end_o) == e.we, "R6", {e.tag, " win_end"}, win_end_o, e.we);
               chk(int'(dly_o) == e.dly, "R6", {e.tag, " chosen delay"}, dly_o, e.dly);
               chk(!busy_o, "R8", {e.tag, " busy low at done"}, busy_o, 0);
            end
            @(negedge clk);
            chk(!done_o, "R8", "done single cycle", done_o, 0);
            sweeps_done++;
         end
      end
   end

   task automatic set_pass(inout logic [255:0] v, input int lo, input int hi);
      for (int i = lo; i <= hi; i++) v[i] = 1'b1;
   endtask

   task automatic run_sweep(input bit mode, input string tag, input bit poke);
      int target;
      sb.push_back(model(mode, tag));
      exp_idx = 0;
      acks_seen = 0;
      exp_kind = mode;
      lat_cnt = 0;
      target = sweeps_done + 1;
      @(negedge clk);
      start_i = 1'b1;
      mode_i = mode;
      @(negedge clk);
      start_i = 1'b0;
      mode_i = ~mode;
      chk(busy_o, "R1", {tag, " busy after start"}, busy_o, 1);
      chk(dly_o == 8'd0, "R1", {tag, " first code"}, dly_o, 0);
      chk(test_req_o, "R1", {tag, " first request"}, test_req_o, 1);
      chk(!no_win_o, "R8", {tag, " no_win cleared"}, no_win_o, 0);
      fork
         while (sweeps_done < target) @(negedge clk);
         if (poke) begin
            repeat (300) @(negedge clk);
            start_i = 1'b1;  // R1: must be ignored while busy
            @(negedge clk);
            start_i = 1'b0;
         end
      join
      chk(acks_seen == NS, "R2", {tag, " steps per sweep"}, acks_seen, NS);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int hold;
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !test_req_o, "R8", "reset idle", busy_o, 0);
      chk(dly_o == 8'd0 && !no_win_o, "R7", "reset code", dly_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // read path, data window 10..70
      pr = '1; pd = '0; set_pass(pd, 10, 70);
      run_sweep(1'b0, "R3 read 10..70", 1'b0);
      // write path on the same pattern: data flag ignored
      run_sweep(1'b1, "R4 write ignores data", 1'b0);
      // equal runs, earliest kept, with a start poke mid-sweep
      pr = '0; pd = '0; set_pass(pr, 20, 29); set_pass(pr, 100, 109);
      run_sweep(1'b1, "R5 tie earliest", 1'b1);
      // longest run closes at the top code
      pr = '1; pd = '0; set_pass(pd, 5, 9); set_pass(pd, 200, 255);
      run_sweep(1'b0, "R5 run ends at top", 1'b0);
      // single pass at the top code only
      pr = '1; pd = '0; pd[255] = 1'b1;
      run_sweep(1'b0, "R6 single top", 1'b0);
      // single pass at code 0
      pr = '0; pr[0] = 1'b1; pd = '0;
      run_sweep(1'b1, "R6 single zero", 1'b0);
      // no pass
      pr = '0; pd = '1;
      run_sweep(1'b1, "R7 empty", 1'b0);
      // read path: response errors veto good data
      pr = '1; pr[40] = 1'b0; pd = '0; set_pass(pd, 30, 60);
      run_sweep(1'b0, "R3 rsp veto", 1'b0);

      hold = dly_o;
      repeat (6) @(negedge clk);
      chk(int'(dly_o) == hold, "R8", "result held while idle", dly_o, hold);
      chk(sb.size() == 0, "R8", "all sweeps completed", sb.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule